// File: doc/BRIEF.md
# Mask Register Shift-Left Unit

This execution unit holds a small file of 64-bit mask registers and applies a left shift by an immediate count to one of them, writing the result into another (or the same) register. A decoded strobe, a 2-bit width select, the operand-addressing byte and the 8-bit immediate describe each operation. The unit shifts within the selected width (8, 16, 32 or 64 bits) and always clears the register bits above that width.

The count is the whole 8-bit immediate and is not reduced modulo the width. If it is past the top bit of the width, the result is zero. Only the register-direct form of the addressing byte is legal. Any other form raises a one-cycle illegal flag and changes no register. A separate load port lets neighbouring logic place values in the registers. A read port gives the contents of any register.

Top module: `mask_shl_unit`

## Requirements
- R1: `width_sel_i` selects the operand width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R2: The shift count is all eight bits of `imm_i`, with no modulo reduction. For example, a count of 8 on the 8-bit width does not act as a count of 0.
- R3: When the count is greater than the width minus one (7, 15, 31, 63), the destination is written with all zeros.
- R4: For an in-range count, the low width bits of the destination are the low width bits of the source shifted left by the count, with zeros entering at bit 0.
- R5: Every destination bit at or above the selected width is written as zero. Upper bits are never kept.
- R6: The destination index is `modrm_i[5:3]` and the source index is `modrm_i[2:0]`.
- R7: If `modrm_i[7:6]` is not 2'b11, `illegal_o` is high in the next cycle, `done_o` stays low and no register changes.
- R8: A legal strobe gives `done_o` high for exactly the next cycle. In that same cycle the new value is visible on `rd_data_o`.
- R9: When the source and destination are the same register, the old value is shifted. An operation strobed in the cycle right after another one sees the updated register.
- R10: Reset clears all mask registers, `done_o` and `illegal_o`.
- R11: `ld_valid_i` writes `ld_data_i` into register `ld_idx_i`. If a legal operation writes in the same cycle, the operation's result wins and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Decoded shift operation strobe |
| width_sel_i | input | 2 | Operand width select |
| modrm_i | input | 8 | Addressing byte: mode [7:6], destination [5:3], source [2:0] |
| imm_i | input | 8 | Shift count |
| ld_valid_i | input | 1 | Load port strobe |
| ld_idx_i | input | 3 | Load port register index |
| ld_data_i | input | 64 | Load port data |
| rd_idx_i | input | 3 | Read port register index |
| rd_data_o | output | 64 | Read port data (combinational) |
| done_o | output | 1 | Pulse one cycle after a legal operation |
| illegal_o | output | 1 | Pulse one cycle after an illegal addressing mode |

## Verification
The assertions assume every input is at a known value whenever reset is released. They also assume the strobe and the mode field are stable around the clock edge, so a `$past` of the decoded legality gives the operation that was really issued. The stimulus drives every input on the falling edge and keeps each one at a defined value throughout. Random operations draw counts from both the in-range band and the full 8-bit range, and about one operation in eight uses a non-register mode. Loads and back-to-back operations are placed where the bench model can follow them cycle by cycle.

// File: rtl/mask_shl_pkg.sv
package mask_shl_pkg;
  localparam int MASK_W     = 64;
  localparam int NUM_REGS   = 8;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int NUM_WIDTHS = 4;
  localparam int CNT_W      = 8;

  typedef enum logic [1:0] {
    WSEL_8  = 2'd0,
    WSEL_16 = 2'd1,
    WSEL_32 = 2'd2,
    WSEL_64 = 2'd3
  } wsel_e;

  localparam logic [1:0] MODE_REG = 2'b11;
endpackage

// File: rtl/mask_shl_core.sv
module mask_shl_core
  import mask_shl_pkg::*;
(
  input  logic [MASK_W-1:0] src_i,
  input  logic [1:0]        width_sel_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [MASK_W-1:0] res_o
);
  logic [MASK_W-1:0] cand [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int W = 8 << g;
    localparam logic [MASK_W-1:0] WMASK = {MASK_W{1'b1}} >> (MASK_W - W);
    always_comb begin
      if (int'(cnt_i) > W - 1) cand[g] = '0;
      else                     cand[g] = (src_i << cnt_i) & WMASK;
    end
  end

  assign res_o = cand[width_sel_i];
endmodule

// File: rtl/mask_shl_regfile.sv
module mask_shl_regfile
  import mask_shl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [MASK_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_a_i,
  output logic [MASK_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0]  raddr_b_i,
  output logic [MASK_W-1:0] rdata_b_o
);
  logic [MASK_W-1:0] mem [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem[r] <= '0;
      else if (we_i && waddr_i == IDX_W'(r))   mem[r] <= wdata_i;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];

  assert_write_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/mask_shl_unit.sv
module mask_shl_unit
  import mask_shl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [1:0]         width_sel_i,
  input  logic [7:0]         modrm_i,
  input  logic [CNT_W-1:0]   imm_i,
  input  logic               ld_valid_i,
  input  logic [IDX_W-1:0]   ld_idx_i,
  input  logic [MASK_W-1:0]  ld_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [MASK_W-1:0]  rd_data_o,
  output logic               done_o,
  output logic               illegal_o
);
  logic [1:0]        mode;
  logic [IDX_W-1:0]  dst_idx, src_idx;
  logic              op_legal, op_bad;
  logic [MASK_W-1:0] src_val, exec_res;
  logic              we;
  logic [IDX_W-1:0]  waddr;
  logic [MASK_W-1:0] wdata;
  logic              done_q, illegal_q;

  assign mode     = modrm_i[7:6];
  assign dst_idx  = modrm_i[3 +: IDX_W];
  assign src_idx  = modrm_i[0 +: IDX_W];
  assign op_legal = op_valid_i && (mode == MODE_REG);
  assign op_bad   = op_valid_i && (mode != MODE_REG);

  mask_shl_core u_core (
    .src_i       (src_val),
    .width_sel_i (width_sel_i),
    .cnt_i       (imm_i),
    .res_o       (exec_res)
  );

  // operation result has priority over the load port
  assign we    = op_legal || ld_valid_i;
  assign waddr = op_legal ? dst_idx  : ld_idx_i;
  assign wdata = op_legal ? exec_res : ld_data_i;

  mask_shl_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (src_idx),
    .rdata_a_o (src_val),
    .raddr_b_i (rd_idx_i),
    .rdata_b_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= op_legal;
      illegal_q <= op_bad;
    end
  end

  assign done_o    = done_q;
  assign illegal_o = illegal_q;

  // checker-side width limit, independent of the core's mask generation
  logic [7:0] chk_limit;
  always_comb begin
    unique case (width_sel_i)
      WSEL_8:  chk_limit = 8'd7;
      WSEL_16: chk_limit = 8'd15;
      WSEL_32: chk_limit = 8'd31;
      default: chk_limit = 8'd63;
    endcase
  end

  assert_over_limit_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_legal && imm_i > chk_limit) |-> exec_res == '0);
  assert_upper_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_legal && width_sel_i != WSEL_64) |-> (exec_res >> (chk_limit + 8'd1)) == '0);
  assert_done_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_legal |=> done_o && !illegal_o);
  assert_illegal_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_bad |=> illegal_o && !done_o);
  assert_no_spurious_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !done_o && !illegal_o);
endmodule

// File: tb/mask_shl_unit_test.sv
`timescale 1ns/1ps
module mask_shl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, ld_valid;
  logic [1:0]  wsel;
  logic [7:0]  modrm, imm;
  logic [2:0]  ld_idx, rd_idx;
  logic [63:0] ld_data, rd_data;
  logic        done, illegal;

  int vectors = 0;
  int errors  = 0;
  logic [63:0] model [8];

  always #2.5 clk = ~clk;

  mask_shl_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .width_sel_i(wsel),
    .modrm_i(modrm), .imm_i(imm), .ld_valid_i(ld_valid), .ld_idx_i(ld_idx),
    .ld_data_i(ld_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .done_o(done), .illegal_o(illegal)
  );

  function automatic logic [63:0] ref_shl(logic [63:0] src, logic [1:0] ws, logic [7:0] cnt);
    int w = 8 << ws;
    logic [63:0] r = '0;
    if (int'(cnt) < w)
      for (int b = 0; b < w; b++)
        if (b >= int'(cnt)) r[b] = src[b - int'(cnt)];
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(string req, logic [2:0] idx);
    rd_idx = idx;
    #0.5;
    check(req, rd_data, model[idx]);
  endtask

  task automatic load(logic [2:0] idx, logic [63:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
    model[idx] = d;
    read_chk("R11 load", idx);
  endtask

  task automatic do_op(string req, logic [1:0] ws, logic [7:0] m, logic [7:0] cnt);
    logic legal = (m[7:6] == 2'b11);
    @(negedge clk);
    op_valid = 1'b1; wsel = ws; modrm = m; imm = cnt;
    @(negedge clk);
    op_valid = 1'b0;
    check({req, " R8 done"}, 64'(done), 64'(legal));
    check({req, " R7 illegal"}, 64'(illegal), 64'(!legal));
    if (legal) model[m[5:3]] = ref_shl(model[m[2:0]], ws, cnt);
    read_chk(req, m[5:3]);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; op_valid = 0; ld_valid = 0; wsel = 0; modrm = 0; imm = 0;
    ld_idx = 0; ld_data = 0; rd_idx = 0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 done", 64'(done), 64'd0);
    check("R10 illegal", 64'(illegal), 64'd0);
    for (int i = 0; i < 8; i++) read_chk("R10 regs", 3'(i));

    // R1 R4 R5 directed: all-ones source, each width, boundary counts
    for (int ws = 0; ws < 4; ws++) begin
      int w = 8 << ws;
      load(3'd1, '1);
      do_op("R4 R5 count0", 2'(ws), {2'b11, 3'd2, 3'd1}, 8'd0);
      do_op("R4 R5 count w-1", 2'(ws), {2'b11, 3'd3, 3'd1}, 8'(w - 1));
      do_op("R2 R3 count w", 2'(ws), {2'b11, 3'd4, 3'd1}, 8'(w));
      do_op("R2 R3 count 255", 2'(ws), {2'b11, 3'd5, 3'd1}, 8'd255);
      do_op("R2 count w+1", 2'(ws), {2'b11, 3'd6, 3'd1}, 8'(w + 1));
    end

    // R6 index fields and R9 same register
    load(3'd7, 64'h8000_0000_0000_0001);
    do_op("R6 R9 self", 2'd3, {2'b11, 3'd7, 3'd7}, 8'd3);
    do_op("R9 self again", 2'd3, {2'b11, 3'd7, 3'd7}, 8'd1);

    // R7 illegal modes leave registers untouched
    load(3'd0, 64'hDEAD_BEEF_0123_4567);
    load(3'd2, 64'hFFFF_0000_FFFF_0000);
    do_op("R7 mode00", 2'd3, {2'b00, 3'd2, 3'd0}, 8'd4);
    do_op("R7 mode01", 2'd0, {2'b01, 3'd2, 3'd0}, 8'd1);
    do_op("R7 mode10", 2'd1, {2'b10, 3'd2, 3'd0}, 8'd2);

    // R9 back-to-back: second op reads first op's destination
    load(3'd3, 64'h0000_0000_0000_00F1);
    @(negedge clk);
    op_valid = 1; wsel = 2'd2; modrm = {2'b11, 3'd4, 3'd3}; imm = 8'd4;
    @(negedge clk);
    model[4] = ref_shl(model[3], 2'd2, 8'd4);
    check("R9 b2b done1", 64'(done), 64'd1);
    wsel = 2'd1; modrm = {2'b11, 3'd5, 3'd4}; imm = 8'd2;
    @(negedge clk);
    op_valid = 0;
    model[5] = ref_shl(model[4], 2'd1, 8'd2);
    check("R9 b2b done2", 64'(done), 64'd1);
    read_chk("R9 b2b first", 3'd4);
    read_chk("R9 b2b second", 3'd5);

    // R11 collision: op wins over load on same register
    load(3'd6, 64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    op_valid = 1; wsel = 2'd3; modrm = {2'b11, 3'd1, 3'd6}; imm = 8'd8;
    ld_valid = 1; ld_idx = 3'd1; ld_data = 64'hAAAA_AAAA_AAAA_AAAA;
    @(negedge clk);
    op_valid = 0; ld_valid = 0;
    model[1] = ref_shl(model[6], 2'd3, 8'd8);
    read_chk("R11 collision", 3'd1);

    // random mix
    for (int i = 0; i < 8; i++) load(3'(i), {$urandom, $urandom});
    for (int n = 0; n < 400; n++) begin
      logic [1:0] mo = ($urandom_range(7) == 0) ? 2'($urandom_range(2)) : 2'b11;
      logic [7:0] c  = $urandom_range(1) ? 8'($urandom_range(70)) : 8'($urandom);
      if ($urandom_range(15) == 0) load(3'($urandom), {$urandom, $urandom});
      do_op("R1 R2 R3 R4 random", 2'($urandom), {mo, 3'($urandom), 3'($urandom)}, c);
    end

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) read_chk("R10 rereset", 3'(i));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule